// File: doc/BRIEF.md
# Power-Down and Busy-State Controller

This block sits behind the serial command front-end of a flash memory. It knows whether the device is awake, settling into or out of deep power-down, or asleep. It also knows whether a self-timed program or erase cycle is running. The front-end presents each opcode byte on `op_code` and asks, through the combinational `op_accept`, whether that opcode may be taken in the current state. An accepted opcode is held until chip-select is released, and only then does it take effect.

`op_valid`/`op_accept` form a valid/ready pair for opcode bytes. A byte is taken only on a clock edge where both are high while `cs_n` is low. `op_accept` depends only on `op_code` and the internal state, never on `op_valid`. A refused byte is discarded and not held for retry, so back-pressure here means rejection. The front-end must resend a refused command in a later frame.

The block models the self-timed busy period with a down-counter. The counter is loaded with a cycle count that depends on the operation class. The same counter structure times the recovery delay on entering and leaving power-down. The status outputs give the ready/busy bit, the failure-report bit, and the write-enable latch.

Top module: `pwrbusy_ctrl`

## Requirements
- R1: After reset, `sts_busy`, `sts_err`, `sts_wel` and `sleeping` are all 0, and the status-read (05h), write-enable (06h) and power-down (B9h) opcodes are accepted.
- R2: Write-enable (06h) sets `sts_wel` when chip-select rises. Program (02h), block erase (20h, 52h, D8h) and chip erase (60h, C7h) are accepted only while `sts_wel` is 1.
- R3: An accepted program or erase starts at the chip-select rise. `sts_busy` is then high for exactly PROG_CYCLES, BLOCK_ERASE_CYCLES or CHIP_ERASE_CYCLES cycles, according to the opcode class.
- R4: While `sts_busy` is 1, only status-read (05h) is accepted. A power-down sent during a busy period is dropped and does not take effect after the period ends.
- R5: In the cycle `sts_busy` falls, `sts_wel` clears and `sts_err` takes the value of `fail_flag` sampled at that edge.
- R6: `sts_err` keeps its value until the next program or erase starts, and clears in the cycle `sts_busy` rises.
- R7: An accepted power-down (B9h) takes effect at the chip-select rise. `sleeping` rises SLEEP_ENTRY_CYCLES cycles later, and no opcode is accepted in between.
- R8: While `sleeping` is 1, only the wake opcode (ABh) is accepted. Any other opcode leaves `sts_busy`, `sts_wel` and `sleeping` unchanged.
- R9: An accepted wake opcode takes effect at the chip-select rise. `sleeping` falls at once, and nothing is accepted for WAKE_CYCLES cycles. The wake opcode is refused while the device is awake.
- R10: Nothing takes effect before chip-select rises. Only the first accepted opcode in a frame is kept, and any opcode not listed above is refused.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip-select, active low; its rise ends a frame |
| op_valid | input | 1 | Opcode byte present on `op_code` this cycle |
| op_code | input | 8 | Opcode byte from the front-end |
| fail_flag | input | 1 | Failure indication from the program/erase verify logic |
| op_accept | output | 1 | `op_code` may be accepted in the current state (combinational) |
| sts_busy | output | 1 | Status ready/busy bit, 1 while a self-timed cycle runs |
| sts_err | output | 1 | Status failure-report bit |
| sts_wel | output | 1 | Write-enable latch |
| sleeping | output | 1 | Device is in deep power-down |

## Verification
The bench runs program, block erase and chip erase, each with and without a reported failure, so that busy length and error capture are seen per class. Power-down and wake commands are sent from each state: awake, busy, asleep and already awake. This separates acceptance that depends on state from acceptance that depends on the opcode. The bench also uses a frame held open after an accepted opcode, a frame carrying two opcodes, and an unknown opcode. These show that execution is tied to the chip-select rise and that only the first byte of a frame counts.

// File: rtl/pwrbusy_pkg.sv
`timescale 1ns/1ps
package pwrbusy_pkg;

  // Opcode values recognised by the controller
  localparam logic [7:0] OPC_RD_STATUS   = 8'h05;
  localparam logic [7:0] OPC_WR_ENABLE   = 8'h06;
  localparam logic [7:0] OPC_PROGRAM     = 8'h02;
  localparam logic [7:0] OPC_ERASE_4K    = 8'h20;
  localparam logic [7:0] OPC_ERASE_32K   = 8'h52;
  localparam logic [7:0] OPC_ERASE_64K   = 8'hD8;
  localparam logic [7:0] OPC_ERASE_ALL_A = 8'h60;
  localparam logic [7:0] OPC_ERASE_ALL_B = 8'hC7;
  localparam logic [7:0] OPC_SLEEP       = 8'hB9;
  localparam logic [7:0] OPC_WAKE        = 8'hAB;

  typedef enum logic [2:0] {
    CLS_NONE,
    CLS_STATUS,
    CLS_WREN,
    CLS_PROG,
    CLS_ERASE_BLK,
    CLS_ERASE_CHIP,
    CLS_SLEEP,
    CLS_WAKE
  } op_class_e;

  typedef enum logic [1:0] {
    PM_AWAKE,
    PM_ENTERING,
    PM_ASLEEP,
    PM_WAKING
  } pwr_mode_e;

  function automatic logic is_array_op(op_class_e c);
    return (c == CLS_PROG) || (c == CLS_ERASE_BLK) || (c == CLS_ERASE_CHIP);
  endfunction

endpackage

// File: rtl/pwrbusy_decode.sv
`timescale 1ns/1ps
module pwrbusy_decode
  import pwrbusy_pkg::*;
(
  input  logic [7:0] op_code,
  output op_class_e  op_cls
);

  always_comb begin
    unique case (op_code)
      OPC_RD_STATUS:                    op_cls = CLS_STATUS;
      OPC_WR_ENABLE:                    op_cls = CLS_WREN;
      OPC_PROGRAM:                      op_cls = CLS_PROG;
      OPC_ERASE_4K, OPC_ERASE_32K,
      OPC_ERASE_64K:                    op_cls = CLS_ERASE_BLK;
      OPC_ERASE_ALL_A, OPC_ERASE_ALL_B: op_cls = CLS_ERASE_CHIP;
      OPC_SLEEP:                        op_cls = CLS_SLEEP;
      OPC_WAKE:                         op_cls = CLS_WAKE;
      default:                          op_cls = CLS_NONE;
    endcase
  end

endmodule

// File: rtl/pwrbusy_timer.sv
`timescale 1ns/1ps
// Loadable down-counter: active while non-zero, expire in its last cycle
module pwrbusy_timer #(
  parameter int unsigned W = 8
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         active,
  output logic         expire
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);
  assign expire = (cnt == W'(1));

endmodule

// File: rtl/pwrbusy_array.sv
`timescale 1ns/1ps
// Self-timed program/erase tracking: busy period, failure bit, write latch
module pwrbusy_array
  import pwrbusy_pkg::*;
#(
  parameter int unsigned PROG_CYCLES        = 64,
  parameter int unsigned BLOCK_ERASE_CYCLES = 256,
  parameter int unsigned CHIP_ERASE_CYCLES  = 1024
)(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  op_class_e start_cls,
  input  logic      wel_set,
  input  logic      fail_flag,
  output logic      busy,
  output logic      err,
  output logic      wel
);

  localparam int unsigned LONG_A  = (PROG_CYCLES > BLOCK_ERASE_CYCLES) ? PROG_CYCLES : BLOCK_ERASE_CYCLES;
  localparam int unsigned LONGEST = (LONG_A > CHIP_ERASE_CYCLES) ? LONG_A : CHIP_ERASE_CYCLES;
  localparam int unsigned W       = $clog2(LONGEST + 1);

  logic [W-1:0] load_val;
  logic         done;

  always_comb begin
    unique case (start_cls)
      CLS_PROG:      load_val = W'(PROG_CYCLES);
      CLS_ERASE_BLK: load_val = W'(BLOCK_ERASE_CYCLES);
      default:       load_val = W'(CHIP_ERASE_CYCLES);
    endcase
  end

  pwrbusy_timer #(.W(W)) u_busy_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .load_val (load_val),
    .active   (busy),
    .expire   (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     err <= 1'b0;
    else if (start) err <= 1'b0;
    else if (done)  err <= fail_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wel <= 1'b0;
    else if (done)    wel <= 1'b0;
    else if (wel_set) wel <= 1'b1;
  end

endmodule

// File: rtl/pwrbusy_power.sv
`timescale 1ns/1ps
// Power mode sequencer with recovery delays on entry and exit
module pwrbusy_power
  import pwrbusy_pkg::*;
#(
  parameter int unsigned SLEEP_ENTRY_CYCLES = 8,
  parameter int unsigned WAKE_CYCLES        = 16
)(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      go_sleep,
  input  logic      go_wake,
  output pwr_mode_e mode,
  output logic      settling
);

  localparam int unsigned LONGEST = (SLEEP_ENTRY_CYCLES > WAKE_CYCLES) ? SLEEP_ENTRY_CYCLES : WAKE_CYCLES;
  localparam int unsigned W       = $clog2(LONGEST + 1);

  logic [W-1:0] load_val;
  logic         done;

  assign load_val = go_sleep ? W'(SLEEP_ENTRY_CYCLES) : W'(WAKE_CYCLES);

  pwrbusy_timer #(.W(W)) u_rec_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (go_sleep | go_wake),
    .load_val (load_val),
    .active   (settling),
    .expire   (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mode <= PM_AWAKE;
    else if (go_sleep) mode <= PM_ENTERING;
    else if (go_wake)  mode <= PM_WAKING;
    else if (done) begin
      unique case (mode)
        PM_ENTERING: mode <= PM_ASLEEP;
        PM_WAKING:   mode <= PM_AWAKE;
        default:     mode <= mode;
      endcase
    end
  end

endmodule

// File: rtl/pwrbusy_ctrl.sv
`timescale 1ns/1ps
module pwrbusy_ctrl
  import pwrbusy_pkg::*;
#(
  parameter int unsigned PROG_CYCLES        = 64,
  parameter int unsigned BLOCK_ERASE_CYCLES = 256,
  parameter int unsigned CHIP_ERASE_CYCLES  = 1024,
  parameter int unsigned SLEEP_ENTRY_CYCLES = 8,
  parameter int unsigned WAKE_CYCLES        = 16
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       op_valid,
  input  logic [7:0] op_code,
  input  logic       fail_flag,
  output logic       op_accept,
  output logic       sts_busy,
  output logic       sts_err,
  output logic       sts_wel,
  output logic       sleeping
);

  op_class_e in_cls;
  op_class_e pend_cls;
  logic      pend_vld;
  logic      cs_q;
  logic      cs_rise;
  logic      exec;
  logic      take;
  pwr_mode_e mode;
  logic      settling;

  pwrbusy_decode u_dec (
    .op_code (op_code),
    .op_cls  (in_cls)
  );

  // Which opcodes the current state admits
  always_comb begin
    op_accept = 1'b0;
    if (!settling) begin
      unique case (mode)
        PM_ASLEEP: op_accept = (in_cls == CLS_WAKE);
        PM_AWAKE: begin
          if (sts_busy) begin
            op_accept = (in_cls == CLS_STATUS);
          end else begin
            unique case (in_cls)
              CLS_STATUS, CLS_WREN, CLS_SLEEP:           op_accept = 1'b1;
              CLS_PROG, CLS_ERASE_BLK, CLS_ERASE_CHIP:   op_accept = sts_wel;
              default:                                   op_accept = 1'b0;
            endcase
          end
        end
        default: op_accept = 1'b0;
      endcase
    end
  end

  assign cs_rise = cs_n & ~cs_q;
  assign take    = op_valid & op_accept & ~cs_n & ~pend_vld;
  assign exec    = cs_rise & pend_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q     <= 1'b1;
      pend_vld <= 1'b0;
      pend_cls <= CLS_NONE;
    end else begin
      cs_q <= cs_n;
      if (cs_rise) begin
        pend_vld <= 1'b0;
      end else if (take) begin
        pend_vld <= 1'b1;
        pend_cls <= in_cls;
      end
    end
  end

  pwrbusy_array #(
    .PROG_CYCLES        (PROG_CYCLES),
    .BLOCK_ERASE_CYCLES (BLOCK_ERASE_CYCLES),
    .CHIP_ERASE_CYCLES  (CHIP_ERASE_CYCLES)
  ) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (exec & is_array_op(pend_cls)),
    .start_cls (pend_cls),
    .wel_set   (exec & (pend_cls == CLS_WREN)),
    .fail_flag (fail_flag),
    .busy      (sts_busy),
    .err       (sts_err),
    .wel       (sts_wel)
  );

  pwrbusy_power #(
    .SLEEP_ENTRY_CYCLES (SLEEP_ENTRY_CYCLES),
    .WAKE_CYCLES        (WAKE_CYCLES)
  ) u_power (
    .clk      (clk),
    .rst_n    (rst_n),
    .go_sleep (exec & (pend_cls == CLS_SLEEP)),
    .go_wake  (exec & (pend_cls == CLS_WAKE)),
    .mode     (mode),
    .settling (settling)
  );

  assign sleeping = (mode == PM_ASLEEP);

endmodule

// File: rtl/pwrbusy_ctrl_chk.sv
`timescale 1ns/1ps
module pwrbusy_ctrl_chk
  import pwrbusy_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic [7:0] op_code,
  input logic       op_accept,
  input logic       sts_busy,
  input logic       sts_err,
  input logic       sts_wel,
  input logic       sleeping
);

  // R2: array operations only admitted with the write latch set
  p_prog_needs_wel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_accept && (op_code == OPC_PROGRAM)) |-> sts_wel);

  // R3: busy starts only at a chip-select rise
  p_busy_at_cs_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_busy) |-> ($past(cs_n) && !$past(cs_n, 2)));

  // R4: only status read while busy
  p_busy_status_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_busy && op_accept) |-> (op_code == OPC_RD_STATUS));

  // R4: never asleep during a busy period
  p_no_sleep_when_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sts_busy |-> !sleeping);

  // R5: write latch cleared on completion
  p_wel_clear_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts_busy) |-> !sts_wel);

  // R6: failure bit cleared at start
  p_err_clear_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_busy) |-> !sts_err);

  // R6: failure bit changes only at the start or end of a busy period
  p_err_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_err != $past(sts_err)) |-> ($rose(sts_busy) || $fell(sts_busy)));

  // R8: only wake admitted while asleep
  p_sleep_wake_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping && op_accept) |-> (op_code == OPC_WAKE));

  // R9: recovery after wake blocks all opcodes
  p_wake_recovery_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleeping) |-> !op_accept);

endmodule

bind pwrbusy_ctrl pwrbusy_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .op_code   (op_code),
  .op_accept (op_accept),
  .sts_busy  (sts_busy),
  .sts_err   (sts_err),
  .sts_wel   (sts_wel),
  .sleeping  (sleeping)
);

// File: tb/tb_pwrbusy_ctrl.sv
`timescale 1ns/1ps
module tb_pwrbusy_ctrl;

  localparam int P_PROG  = 12;
  localparam int P_BLK   = 20;
  localparam int P_CHIP  = 30;
  localparam int P_ENTRY = 3;
  localparam int P_WAKE  = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       op_valid = 1'b0;
  logic [7:0] op_code = 8'h00;
  logic       fail_flag = 1'b0;
  logic       op_accept, sts_busy, sts_err, sts_wel, sleeping;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pwrbusy_ctrl #(
    .PROG_CYCLES        (P_PROG),
    .BLOCK_ERASE_CYCLES (P_BLK),
    .CHIP_ERASE_CYCLES  (P_CHIP),
    .SLEEP_ENTRY_CYCLES (P_ENTRY),
    .WAKE_CYCLES        (P_WAKE)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .op_valid(op_valid), .op_code(op_code),
    .fail_flag(fail_flag), .op_accept(op_accept), .sts_busy(sts_busy),
    .sts_err(sts_err), .sts_wel(sts_wel), .sleeping(sleeping)
  );

  // ---------------- behavioural reference model ----------------
  int         m_busy = 0;   // remaining busy cycles
  int         m_rec  = 0;   // remaining recovery cycles
  int         m_mode = 0;   // 0 awake, 1 entering, 2 asleep, 3 waking
  bit         m_err = 0, m_wel = 0, m_pend = 0, m_csq = 1;
  logic [7:0] m_pop = 8'h00;

  function automatic int busy_len(logic [7:0] op);
    case (op)
      8'h02:               return P_PROG;
      8'h20, 8'h52, 8'hD8: return P_BLK;
      8'h60, 8'hC7:        return P_CHIP;
      default:             return 0;
    endcase
  endfunction

  function automatic bit m_acc(logic [7:0] op);
    if (m_rec > 0)   return 1'b0;
    if (m_mode == 2) return (op == 8'hAB);
    if (m_busy > 0)  return (op == 8'h05);
    case (op)
      8'h05, 8'h06, 8'hB9: return 1'b1;
      default:             return (busy_len(op) > 0) ? m_wel : 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_rec = 0; m_mode = 0;
      m_err = 0; m_wel = 0; m_pend = 0; m_csq = 1;
    end else begin
      bit acc;
      bit rise;
      acc  = m_acc(op_code);
      rise = cs_n && !m_csq;
      if (m_busy == 1) begin m_err = fail_flag; m_wel = 0; end
      if (m_busy > 0) m_busy--;
      if (m_rec == 1) m_mode = (m_mode == 1) ? 2 : 0;
      if (m_rec > 0) m_rec--;
      if (op_valid && !cs_n && !m_pend && acc) begin
        m_pend = 1; m_pop = op_code;
      end else if (rise && m_pend) begin
        m_pend = 0;
        case (m_pop)
          8'h06: m_wel = 1;
          8'hB9: begin m_mode = 1; m_rec = P_ENTRY; end
          8'hAB: begin m_mode = 3; m_rec = P_WAKE; end
          default: if (busy_len(m_pop) > 0) begin m_busy = busy_len(m_pop); m_err = 0; end
        endcase
      end
      m_csq = cs_n;
    end
  end

  task automatic cmp(string tag, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      cmp("R3 busy vs model", sts_busy, (m_busy > 0));
      cmp("R5 err vs model", sts_err, m_err);
      cmp("R2 wel vs model", sts_wel, m_wel);
      cmp("R7 sleeping vs model", sleeping, (m_mode == 2));
      cmp("R4 accept vs model", op_accept, m_acc(op_code));
    end
  end

  // ---------------- directed checks ----------------
  task automatic chk(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic frame(input logic [7:0] a, input bit two = 1'b0, input logic [7:0] b = 8'h00);
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk); op_valid = 1'b1; op_code = a;
    @(negedge clk); if (two) op_code = b; else op_valid = 1'b0;
    @(negedge clk); op_valid = 1'b0;
    @(negedge clk); cs_n = 1'b1;
  endtask

  // which: 0 count busy cycles, 1 count cycles before sleeping, 2 count refused cycles
  task automatic count_while(input int which, output int n);
    bit c;
    n = 0;
    forever begin
      @(negedge clk); #0.5;
      case (which)
        0:       c = sts_busy;
        1:       c = !sleeping;
        default: c = !op_accept;
      endcase
      if (!c || n > 1000) break;
      n++;
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk); #0.5;
    chk("R1 busy after reset", sts_busy, 0);
    chk("R1 err after reset", sts_err, 0);
    chk("R1 wel after reset", sts_wel, 0);
    chk("R1 sleeping after reset", sleeping, 0);
    op_code = 8'h06; #0.2; chk("R1 write-enable accepted", op_accept, 1);
    op_code = 8'hB9; #0.2; chk("R1 power-down accepted", op_accept, 1);
    op_code = 8'h02; #0.2; chk("R2 program refused without latch", op_accept, 0);

    // R2 program without latch has no effect
    frame(8'h02);
    count_while(0, n); chk("R2 no busy without latch", n, 0);

    // R2/R3/R5 program, no failure
    frame(8'h06);
    @(negedge clk); #0.5; chk("R2 latch set", sts_wel, 1);
    fail_flag = 1'b0;
    frame(8'h02);
    count_while(0, n); chk("R3 program busy length", n, P_PROG);
    chk("R5 latch cleared at end", sts_wel, 0);
    chk("R5 no error", sts_err, 0);

    // R3/R5 block erase with failure
    frame(8'h06);
    fail_flag = 1'b1;
    frame(8'h20);
    count_while(0, n); chk("R3 block erase busy length", n, P_BLK);
    chk("R5 error captured", sts_err, 1);
    fail_flag = 1'b0;

    // R6 error held across other commands
    frame(8'h06);
    frame(8'h05);
    @(negedge clk); #0.5; chk("R6 error held", sts_err, 1);
    frame(8'hC7);
    @(negedge clk); #0.5;
    chk("R6 error cleared at start", sts_err, 0);
    chk("R3 chip erase busy begins", sts_busy, 1);
    count_while(0, n); chk("R3 chip erase remaining busy", n, P_CHIP - 1);

    // R4 power-down during busy is dropped
    frame(8'h06);
    frame(8'h52);
    @(negedge clk);
    op_code = 8'hB9; #0.5; chk("R4 power-down refused while busy", op_accept, 0);
    op_code = 8'h05; #0.2; chk("R4 status accepted while busy", op_accept, 1);
    frame(8'hB9);
    repeat (P_BLK + P_ENTRY + 4) @(negedge clk);
    #0.5; chk("R4 dropped power-down not applied", sleeping, 0);

    // R10 nothing before chip-select rise
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk); op_valid = 1'b1; op_code = 8'h06;
    @(negedge clk); op_valid = 1'b0;
    repeat (3) @(negedge clk);
    #0.5; chk("R10 no effect while frame open", sts_wel, 0);
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk); #0.5; chk("R10 effect after rise", sts_wel, 1);
    op_code = 8'h9F; #0.2; chk("R10 unknown opcode refused", op_accept, 0);
    frame(8'h9F);
    // first byte kept, second dropped
    frame(8'h05, 1'b1, 8'hB9);
    repeat (P_ENTRY + 3) @(negedge clk);
    #0.5; chk("R10 second opcode in frame dropped", sleeping, 0);

    // R7 power-down
    frame(8'hB9);
    count_while(1, n); chk("R7 entry delay", n, P_ENTRY);

    // R8 other opcodes ignored while asleep
    op_code = 8'h05; #0.2; chk("R8 status refused asleep", op_accept, 0);
    op_code = 8'hAB; #0.2; chk("R8 wake accepted asleep", op_accept, 1);
    frame(8'h02);
    frame(8'h06);
    repeat (3) @(negedge clk);
    #0.5;
    chk("R8 no busy from program asleep", sts_busy, 0);
    chk("R8 still asleep", sleeping, 1);
    chk("R8 latch unchanged", sts_wel, 1);

    // R9 wake
    frame(8'hAB);
    op_code = 8'h05;
    count_while(2, n); chk("R9 wake recovery length", n, P_WAKE);
    chk("R9 awake after recovery", sleeping, 0);
    op_code = 8'hAB; #0.2; chk("R9 wake refused when awake", op_accept, 0);
    frame(8'hAB);
    @(negedge clk); #0.5;
    op_code = 8'h05; #0.2; chk("R9 stray wake has no effect", op_accept, 1);

    // R3 program after wake, latch kept from before sleep
    frame(8'h02);
    count_while(0, n); chk("R3 program after wake", n, P_PROG);

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule